// File: doc/BRIEF.md
# Accumulator Processor Core

A small processor whose only working register is a 16-bit accumulator. Every arithmetic instruction takes the accumulator as one operand and a directly addressed 16-bit memory word as the other, and the result goes back into the accumulator. The instruction set has load, store, add, subtract, negate, halt, and nothing else. An opcode is one byte. The four memory instructions are followed by a two-byte direct address, so an instruction is either one byte or three bytes long.

Instruction bytes come from a byte-wide read port, one byte per cycle. Data moves through a separate 16-bit port. Two counters keep a running total of instruction bytes fetched and data bytes moved, so a bench can check the bus traffic of a program exactly. When the core halts, either on the halt opcode or on an opcode it does not know, all of its state freezes and can be read from the ports.

Top module: `acc_core`

## Requirements
- R1: Reset clears all of the following: the accumulator, the program counter (`imem_addr`), both counters and the flags `ovf`, `illegal` and `halted`.
- R2: Opcode 0x01 loads the word at the direct address into the accumulator. Opcode 0x02 writes the accumulator to that address with `dmem_we` and leaves the accumulator unchanged.
- R3: Opcode 0x03 adds the addressed word to the accumulator and opcode 0x04 subtracts it from the accumulator, both modulo 2^16. These two opcodes set `ovf` when the signed result lies outside -32768..32767 and clear it otherwise. All other opcodes leave `ovf` as it is.
- R4: Opcode 0x05 replaces the accumulator with its two's-complement negation and makes no data access. Negating 0x8000 gives 0x8000, and negating 0 gives 0.
- R5: The two address bytes follow the opcode, high byte first. Every fetched byte advances the program counter by one, and one instruction byte is fetched per cycle. A memory instruction takes 4 cycles, and its data access happens in the fourth. Negate takes 1 cycle.
- R6: Opcode 0xFF sets `halted`. After that, the accumulator, the flags, the program counter and both counters stay constant until reset.
- R7: Any opcode other than 0x01 to 0x05 and 0xFF sets both `illegal` and `halted`.
- R8: `ibyte_cnt` goes up by one for each fetched instruction byte, and this includes the halt opcode and an illegal opcode. `dbyte_cnt` goes up by two for each data read or data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 16 | Instruction byte address (the program counter) |
| imem_rdata | input | 8 | Instruction byte, combinational read |
| dmem_addr | output | 16 | Data word address |
| dmem_rdata | input | 16 | Data word read, combinational |
| dmem_wdata | output | 16 | Data word to write |
| dmem_re | output | 1 | Data read this cycle |
| dmem_we | output | 1 | Data write this cycle |
| acc | output | 16 | Accumulator |
| ovf | output | 1 | Signed overflow of the last add or subtract |
| illegal | output | 1 | Unknown opcode seen |
| halted | output | 1 | Core stopped |
| ibyte_cnt | output | CNT_W | Instruction bytes fetched |
| dbyte_cnt | output | CNT_W | Data bytes moved |

## Verification
The assertions assume three things about the inputs. Both memories answer in the same cycle as the request. The program stays inside the memory that was loaded. Reset is held for at least one clock edge. The bench keeps within these limits: its memories are combinational arrays, every program ends in a halt or an illegal opcode, and the program image is loaded while reset is held. It uses addresses whose two bytes differ, so a core that swapped the high and low address bytes would read a different stored value.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [15:0]      imem_addr,
  input  logic [7:0]       imem_rdata,
  output logic [15:0]      dmem_addr,
  input  logic [15:0]      dmem_rdata,
  output logic [15:0]      dmem_wdata,
  output logic             dmem_re,
  output logic             dmem_we,
  output logic [15:0]      acc,
  output logic             ovf,
  output logic             illegal,
  output logic             halted,
  output logic [CNT_W-1:0] ibyte_cnt,
  output logic [CNT_W-1:0] dbyte_cnt
);
  localparam logic [7:0] OP_LD = 8'h01, OP_ST = 8'h02, OP_ADD = 8'h03,
                         OP_SUB = 8'h04, OP_NEG = 8'h05, OP_HLT = 8'hFF;

  typedef enum logic [1:0] {S_OP, S_AHI, S_ALO, S_EX} st_t;

  st_t             st;
  logic [15:0]     pc, acc_q;
  logic [7:0]      op, ahi, alo;
  logic            ovf_q, ill_q, halt_q;
  logic [CNT_W-1:0] icnt, dcnt;
  logic [15:0]     sum, dif;
  logic            exec;

  assign exec       = !halt_q && st == S_EX;
  assign dmem_re    = exec && op != OP_ST;
  assign dmem_we    = exec && op == OP_ST;
  assign dmem_addr  = {ahi, alo};
  assign dmem_wdata = acc_q;
  assign imem_addr  = pc;
  assign sum        = acc_q + dmem_rdata;
  assign dif        = acc_q - dmem_rdata;
  assign acc        = acc_q;
  assign ovf        = ovf_q;
  assign illegal    = ill_q;
  assign halted     = halt_q;
  assign ibyte_cnt  = icnt;
  assign dbyte_cnt  = dcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OP; pc <= '0; acc_q <= '0; op <= '0; ahi <= '0; alo <= '0;
      ovf_q <= 1'b0; ill_q <= 1'b0; halt_q <= 1'b0; icnt <= '0; dcnt <= '0;
    end else if (!halt_q) begin
      case (st)
        S_OP: begin
          pc   <= pc + 16'd1;
          icnt <= icnt + 1'b1;
          op   <= imem_rdata;
          case (imem_rdata)
            OP_LD, OP_ST, OP_ADD, OP_SUB: st <= S_AHI;
            OP_NEG: acc_q <= ~acc_q + 16'd1;
            OP_HLT: halt_q <= 1'b1;
            default: begin ill_q <= 1'b1; halt_q <= 1'b1; end
          endcase
        end
        S_AHI: begin
          ahi <= imem_rdata; pc <= pc + 16'd1; icnt <= icnt + 1'b1; st <= S_ALO;
        end
        S_ALO: begin
          alo <= imem_rdata; pc <= pc + 16'd1; icnt <= icnt + 1'b1; st <= S_EX;
        end
        S_EX: begin
          dcnt <= dcnt + 2'd2;
          st   <= S_OP;
          case (op)
            OP_LD:  acc_q <= dmem_rdata;
            OP_ADD: begin
              acc_q <= sum;
              ovf_q <= (acc_q[15] == dmem_rdata[15]) && (sum[15] != acc_q[15]);
            end
            OP_SUB: begin
              acc_q <= dif;
              ovf_q <= (acc_q[15] != dmem_rdata[15]) && (dif[15] != acc_q[15]);
            end
            default: ;
          endcase
        end
        default: st <= S_OP;
      endcase
    end
  end

  a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(acc_q) && $stable(icnt) && $stable(dcnt) && $stable(pc)));

  a_r8_data_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_re || dmem_we) |=> (dcnt == $past(dcnt) + 2));

  a_r5_no_fetch_during_data: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_re || dmem_we) |=> $stable(icnt) && $stable(pc));

  a_r2_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> $stable(acc_q));

  a_r7_illegal_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ill_q) |-> halt_q);

  a_r3_ovf_only_on_arith: assert property (@(posedge clk) disable iff (!rst_n)
    (!dmem_re) |=> $stable(ovf_q));
endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] imem_addr, dmem_addr, dmem_rdata, dmem_wdata, acc;
  logic [7:0]  imem_rdata;
  logic dmem_re, dmem_we, ovf, illegal, halted;
  logic [CW-1:0] ibyte_cnt, dbyte_cnt;

  logic [7:0]  imem  [0:255];
  logic [15:0] dmem  [0:1023];
  logic [15:0] mdmem [0:1023];

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
    .dmem_re(dmem_re), .dmem_we(dmem_we), .acc(acc), .ovf(ovf),
    .illegal(illegal), .halted(halted), .ibyte_cnt(ibyte_cnt), .dbyte_cnt(dbyte_cnt));

  assign imem_rdata = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[9:0]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:0]] <= dmem_wdata;

  // behavioural reference: remaining-byte count per instruction
  logic [15:0] m_pc, m_acc, m_addr;
  logic [7:0]  m_op;
  logic        m_ovf, m_ill, m_halt;
  int          m_step, m_ib, m_db;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_acc = 0; m_addr = 0; m_op = 0; m_ovf = 0; m_ill = 0;
      m_halt = 0; m_step = 0; m_ib = 0; m_db = 0;
    end else if (!m_halt) begin
      if (m_step == 0) begin
        m_op = imem[m_pc[7:0]]; m_pc++; m_ib++;
        if (m_op >= 8'h01 && m_op <= 8'h04) m_step = 1;
        else if (m_op == 8'h05) m_acc = 16'(32'h10000 - {16'h0, m_acc});
        else if (m_op == 8'hFF) m_halt = 1;
        else begin m_ill = 1; m_halt = 1; end
      end else if (m_step == 1) begin
        m_addr[15:8] = imem[m_pc[7:0]]; m_pc++; m_ib++; m_step = 2;
      end else if (m_step == 2) begin
        m_addr[7:0] = imem[m_pc[7:0]]; m_pc++; m_ib++; m_step = 3;
      end else begin
        int a, b, r;
        a = int'($signed(m_acc)); b = int'($signed(mdmem[m_addr[9:0]]));
        m_db += 2; m_step = 0;
        case (m_op)
          8'h01: m_acc = mdmem[m_addr[9:0]];
          8'h02: mdmem[m_addr[9:0]] = m_acc;
          8'h03: begin r = a + b; m_acc = 16'(r); m_ovf = (r > 32767 || r < -32768); end
          default: begin r = a - b; m_acc = 16'(r); m_ovf = (r > 32767 || r < -32768); end
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3", "acc", acc, m_acc);
    chk("R3", "ovf", ovf, m_ovf);
    chk("R7", "illegal", illegal, m_ill);
    chk("R6", "halted", halted, m_halt);
    chk("R5", "pc", imem_addr, m_pc);
    chk("R8", "ibyte_cnt", ibyte_cnt, m_ib);
    chk("R8", "dbyte_cnt", dbyte_cnt, m_db);
    if (!m_halt && m_step == 3) begin
      chk("R5", "dmem_addr", dmem_addr, m_addr);
      chk("R2", "dmem_we", dmem_we, m_op == 8'h02);
      chk("R2", "dmem_re", dmem_re, m_op != 8'h02);
      if (m_op == 8'h02) chk("R2", "dmem_wdata", dmem_wdata, m_acc);
    end else begin
      chk("R4", "no data access", {dmem_re, dmem_we}, 2'b00);
    end
  end

  task automatic put_word(input logic [15:0] a, input logic [15:0] d);
    dmem[a[9:0]] = d; mdmem[a[9:0]] = d;
  endtask

  task automatic start(input int n);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 1024; i++) begin dmem[i] = 16'h0; mdmem[i] = 16'h0; end
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    if (n == 1) begin
      put_word(16'h1234, 16'h7FFF); put_word(16'h0012, 16'h0001);
      put_word(16'h0100, 16'h8000); put_word(16'h0200, 16'h0005);
      imem[0]  = 8'h01; imem[1]  = 8'h12; imem[2]  = 8'h34;
      imem[3]  = 8'h03; imem[4]  = 8'h00; imem[5]  = 8'h12;
      imem[6]  = 8'h04; imem[7]  = 8'h02; imem[8]  = 8'h00;
      imem[9]  = 8'h05;
      imem[10] = 8'h02; imem[11] = 8'h03; imem[12] = 8'h00;
      imem[13] = 8'h01; imem[14] = 8'h01; imem[15] = 8'h00;
      imem[16] = 8'h05;
      imem[17] = 8'h03; imem[18] = 8'h01; imem[19] = 8'h00;
      imem[20] = 8'h01; imem[21] = 8'h02; imem[22] = 8'h00;
      imem[23] = 8'h03; imem[24] = 8'h00; imem[25] = 8'h12;
      imem[26] = 8'h01; imem[27] = 8'h03; imem[28] = 8'h00;
      imem[29] = 8'hFF;
    end else begin
      put_word(16'h0012, 16'h0001);
      imem[0] = 8'h01; imem[1] = 8'h00; imem[2] = 8'h12;
      imem[3] = 8'h05; imem[4] = 8'h07; imem[5] = 8'h01;
    end
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (halted) return;
    end
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog actual=running expected=halted");
  endtask

  initial begin
    fork
      begin
        start(1);
        chk("R1", "reset acc", acc, 16'h0);
        chk("R1", "reset pc", imem_addr, 16'h0);
        chk("R1", "reset counters", {ibyte_cnt, dbyte_cnt}, 64'h0);
        chk("R1", "reset flags", {ovf, illegal, halted}, 3'b000);
        run_to_halt();
        chk("R2", "reload of stored negation", acc, 16'h8005);
        chk("R2", "stored word in memory", dmem[10'h300], 16'h8005);
        chk("R3", "final ovf after 5+1", ovf, 1'b0);
        chk("R8", "instruction bytes", ibyte_cnt, 30);
        chk("R8", "data bytes", dbyte_cnt, 18);
        chk("R5", "pc after halt", imem_addr, 16'd30);
        repeat (5) @(negedge clk);
        chk("R6", "frozen acc", acc, 16'h8005);
        chk("R6", "frozen counter", ibyte_cnt, 30);
        start(2);
        run_to_halt();
        chk("R7", "illegal flag", illegal, 1'b1);
        chk("R4", "negate of 1", acc, 16'hFFFF);
        chk("R8", "bytes with illegal op", ibyte_cnt, 5);
        chk("R8", "data bytes prog2", dbyte_cnt, 2);
        repeat (3) @(negedge clk);
        chk("R7", "no fetch after illegal", imem_addr, 16'd5);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R6 watchdog expired actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule